// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a target is still holding after a transfer was cut short. When started, it holds the neighbouring bus controller in reset and lets go of both lines. It then samples the synchronised SCL and SDA levels. The bus counts as free only when both lines read high. If the bus is busy, the block clocks SCL low and releases it, one pulse at a time. It samples again after each pulse, and it stops at the first sample that finds the bus free or once the pulse budget is used up.

At the end the block lifts the controller reset and raises a one-cycle request to reinitialise the controller. It does this whatever the outcome. It reports completion together with a recovered/failed status that stays valid until the next run. The pulse low time, the settle time before each sample and the pulse budget are parameters counted in clock cycles.

Top module: `busclear_seq`

## Requirements
- R1: After reset, every output (`scl_oe_o`, `sda_oe_o`, `ctrl_rst_o`, `done_o`, `reinit_o`, `ok_o`) is low.
- R2: A start accepted while idle raises `ctrl_rst_o` in the next cycle. `ctrl_rst_o` stays high for the whole run and falls only in the completion cycle.
- R3: The bus is free when the synchronised SCL and SDA both read 1. If the bus is free at the first sample, no SCL pulse is issued and `ok_o` reads 1.
- R4: Each SCL pulse drives `scl_oe_o` (1 = pull SCL low) high for exactly LOW_CYC cycles. SCL is then released for at least SETTLE_CYC cycles before the next sample.
- R5: The sequence stops at the first sample that finds the bus free. The number of pulses equals the number the target needed before it let go.
- R6: At most MAX_PULSES (default 100) pulses are issued. If the bus is still not free at the sample after the last pulse, `ok_o` reads 0.
- R7: In the completion cycle `ctrl_rst_o` is low and `done_o` and `reinit_o` are both high for exactly one cycle, whether recovery succeeded or failed.
- R8: `ok_o` keeps its result from the completion cycle until the next accepted start, which clears it.
- R9: A start request while a run is in progress is ignored: it neither restarts the run nor adds pulses.
- R10: `sda_oe_o` is never asserted. `scl_oe_o` is asserted only while `ctrl_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a recovery run (taken when idle) |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 = pull SCL low |
| sda_oe_o | output | 1 | 1 = pull SDA low (held released) |
| ctrl_rst_o | output | 1 | Holds the bus controller in reset |
| done_o | output | 1 | One-cycle completion strobe |
| reinit_o | output | 1 | One-cycle request to reinitialise the controller |
| ok_o | output | 1 | 1 = bus found free, 0 = recovery failed |

## Verification
A wrong pulse counter shows up as a pulse total that differs from the number of SCL edges the modelled target needs. It also shows up as a wrong `ok_o` at the cap, and both are visible at the `done_o` strobe of that run. A wrong timer load shows up in the first pulse as an SCL low time other than LOW_CYC. A state machine that leaves the reset window early shows up as `ctrl_rst_o` falling without `done_o`. That, or a late `reinit_o`, is caught in the very cycle it happens.

// File: rtl/busclear_pkg.sv
package busclear_pkg;

    typedef enum logic [2:0] {
        BC_IDLE   = 3'd0,
        BC_SETTLE = 3'd1,
        BC_CHECK  = 3'd2,
        BC_LOW    = 3'd3,
        BC_FIN    = 3'd4
    } bc_state_e;

    function automatic int bc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/busclear_sync.sv
module busclear_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    // Reset value 1: an idle bus reads high.
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/busclear_timer.sv
module busclear_timer #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] val_i,
    output logic             expired_o
);
    logic [WIDTH-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)            cnt_d = val_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/busclear_seq.sv
module busclear_seq
    import busclear_pkg::*;
#(
    parameter int MAX_PULSES  = 100,
    parameter int LOW_CYC     = 8,
    parameter int SETTLE_CYC  = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_oe_o,
    output logic sda_oe_o,
    output logic ctrl_rst_o,
    output logic done_o,
    output logic reinit_o,
    output logic ok_o
);
    // Settle must cover the synchroniser so each sample sees the released line.
    localparam int EFF_SETTLE = bc_max(SETTLE_CYC, SYNC_STAGES + 1);
    localparam int EFF_LOW    = bc_max(LOW_CYC, 1);
    localparam int CNT_W      = $clog2(MAX_PULSES + 1);
    localparam int TMR_W      = $clog2(bc_max(EFF_SETTLE, EFF_LOW) + 1);
    localparam logic [TMR_W-1:0] LOW_LOAD    = TMR_W'(EFF_LOW - 1);
    localparam logic [TMR_W-1:0] SETTLE_LOAD = TMR_W'(EFF_SETTLE - 1);
    localparam logic [CNT_W-1:0] CNT_MAX     = CNT_W'(MAX_PULSES);

    typedef struct packed {
        bc_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             scl_oe;
        logic             hold;
        logic             done;
        logic             reinit;
        logic             ok;
    } seq_t;

    seq_t s_d, s_q;

    logic [1:0]       line_s;
    logic             bus_free;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_exp;

    busclear_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_i, sda_i}),
        .sync_o  (line_s)
    );

    busclear_timer #(.WIDTH(TMR_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    assign bus_free = line_s[1] & line_s[0];

    always_comb begin
        s_d      = s_q;
        tmr_load = 1'b0;
        tmr_val  = SETTLE_LOAD;
        s_d.done   = 1'b0;
        s_d.reinit = 1'b0;
        unique case (s_q.st)
            BC_IDLE: begin
                if (start_i) begin
                    s_d.st   = BC_SETTLE;
                    s_d.hold = 1'b1;
                    s_d.ok   = 1'b0;
                    s_d.cnt  = '0;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LOAD;
                end
            end
            BC_SETTLE: begin
                if (tmr_exp) s_d.st = BC_CHECK;
            end
            BC_CHECK: begin
                if (bus_free || (s_q.cnt == CNT_MAX)) begin
                    s_d.st     = BC_FIN;
                    s_d.ok     = bus_free;
                    s_d.hold   = 1'b0;
                    s_d.done   = 1'b1;
                    s_d.reinit = 1'b1;
                end else begin
                    s_d.st     = BC_LOW;
                    s_d.scl_oe = 1'b1;
                    s_d.cnt    = s_q.cnt + 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = LOW_LOAD;
                end
            end
            BC_LOW: begin
                if (tmr_exp) begin
                    s_d.st     = BC_SETTLE;
                    s_d.scl_oe = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = SETTLE_LOAD;
                end
            end
            BC_FIN: begin
                s_d.st = BC_IDLE;
            end
            default: begin
                s_d.st     = BC_IDLE;
                s_d.hold   = 1'b0;
                s_d.scl_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: BC_IDLE, cnt: '0, scl_oe: 1'b0, hold: 1'b0,
                     done: 1'b0, reinit: 1'b0, ok: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign scl_oe_o   = s_q.scl_oe;
    assign sda_oe_o   = 1'b0;
    assign ctrl_rst_o = s_q.hold;
    assign done_o     = s_q.done;
    assign reinit_o   = s_q.reinit;
    assign ok_o       = s_q.ok;
endmodule

// File: rtl/busclear_chk.sv
module busclear_chk #(
    parameter int MAX_PULSES = 100,
    parameter int LOW_CYC    = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic scl_oe_o,
    input logic ctrl_rst_o,
    input logic done_o,
    input logic reinit_o
);
    localparam int PW = $clog2(MAX_PULSES + 2);
    localparam int WW = $clog2(LOW_CYC + 2) + 1;

    logic          oe_prev_q, rst_prev_q;
    logic [PW-1:0] pulses_q;
    logic [WW-1:0] width_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_prev_q  <= 1'b0;
            rst_prev_q <= 1'b0;
            pulses_q   <= '0;
            width_q    <= '0;
        end else begin
            oe_prev_q  <= scl_oe_o;
            rst_prev_q <= ctrl_rst_o;
            if (ctrl_rst_o && !rst_prev_q)     pulses_q <= '0;
            else if (scl_oe_o && !oe_prev_q)   pulses_q <= pulses_q + 1'b1;
            if (scl_oe_o) width_q <= width_q + 1'b1;
            else          width_q <= '0;
        end
    end

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ctrl_rst_o && !done_o) |=> ctrl_rst_o);
    // R2
    rst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_rst_o) |-> done_o);
    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_prev_q && !scl_oe_o) |-> (width_q == WW'(LOW_CYC)));
    // R6
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= PW'(MAX_PULSES));
    // R7
    reinit_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_o |-> (!ctrl_rst_o && $past(ctrl_rst_o) && done_o));
    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    scl_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe_o |-> ctrl_rst_o);
endmodule

bind busclear_seq busclear_chk #(.MAX_PULSES(MAX_PULSES), .LOW_CYC(LOW_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .scl_oe_o   (scl_oe_o),
    .ctrl_rst_o (ctrl_rst_o),
    .done_o     (done_o),
    .reinit_o   (reinit_o)
);

// File: tb/sim_busclear_seq.sv
`timescale 1ns/1ps
module sim_busclear_seq;
    localparam int MAXP = 100;
    localparam int LOWC = 8;
    localparam int NV   = 8;
    // columns: edges needed by target, SCL stuck low, expected pulses, expected ok
    localparam int V_REL [NV] = '{0, 1, 3, 37, 99, 100, 101, 0};
    localparam int V_STK [NV] = '{0, 0, 0, 0,  0,  0,   0,   1};
    localparam int V_PUL [NV] = '{0, 1, 3, 37, 99, 100, 100, 100};
    localparam int V_OK  [NV] = '{1, 1, 1, 1,  1,  1,   0,   0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic scl_i, sda_i;
    logic scl_oe_o, sda_oe_o, ctrl_rst_o, done_o, reinit_o, ok_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    int  need_edges = 0;
    logic stuck = 1'b0;
    logic clr = 1'b0;
    int  edges;
    logic scl_prev;

    always #4 clk = ~clk;

    busclear_seq #(.MAX_PULSES(MAXP), .LOW_CYC(LOWC)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .ctrl_rst_o(ctrl_rst_o),
        .done_o(done_o), .reinit_o(reinit_o), .ok_o(ok_o)
    );

    // Target model: holds SDA low until it has seen need_edges rising SCL edges.
    assign scl_i = stuck ? 1'b0 : ~scl_oe_o;
    assign sda_i = (edges < need_edges) ? 1'b0 : 1'b1;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (clr) begin
            edges <= 0;
            scl_prev <= scl_i;
        end else begin
            scl_prev <= scl_i;
            if (scl_i && !scl_prev) edges <= edges + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One recovery run; returns pulses, low-width errors and window errors.
    task automatic run(input int rel, input logic stk, input logic extra_start,
                       output int pulses, output int okv, output int bad_w,
                       output int bad_win, output int bad_sda);
        int w;
        int t;
        logic prev;
        pulses = 0; bad_w = 0; bad_win = 0; bad_sda = 0; w = 0; prev = 1'b0; t = 0;
        @(negedge clk);
        need_edges = rel; stuck = stk; clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 reset raised after start", int'(ctrl_rst_o), 1);
        chk("R8 ok cleared at start", int'(ok_o), 0);
        while (!done_o && t < 20000) begin
            if (extra_start && t == 40) start_i = 1'b1;
            if (extra_start && t == 41) start_i = 1'b0;
            if (!ctrl_rst_o) bad_win++;
            if (sda_oe_o) bad_sda++;
            if (scl_oe_o) begin
                if (!prev) pulses++;
                w++;
            end else if (prev) begin
                if (w != LOWC) bad_w++;
                w = 0;
            end
            prev = scl_oe_o;
            t++;
            @(negedge clk);
        end
        chk("R7 done reached", int'(done_o), 1);
        chk("R7 reinit with done", int'(reinit_o), 1);
        chk("R7 reset low at completion", int'(ctrl_rst_o), 0);
        okv = int'(ok_o);
        @(negedge clk);
        chk("R7 done one cycle", int'(done_o), 0);
        chk("R7 reinit one cycle", int'(reinit_o), 0);
        repeat (5) @(negedge clk);
        chk("R8 ok held after run", int'(ok_o), okv);
        chk("R7 no second done (R9)", int'(done_o), 0);
    endtask

    initial begin
        int p, o, bw, bwin, bs;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 scl_oe", int'(scl_oe_o), 0);
        chk("R1 sda_oe", int'(sda_oe_o), 0);
        chk("R1 ctrl_rst", int'(ctrl_rst_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 reinit", int'(reinit_o), 0);
        chk("R1 ok", int'(ok_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run(V_REL[i], V_STK[i][0], 1'b0, p, o, bw, bwin, bs);
            if (V_PUL[i] == 0) chk("R3 no pulses when free", p, 0);
            else if (V_OK[i] == 1) chk("R5 pulse count", p, V_PUL[i]);
            else chk("R6 pulse cap", p, V_PUL[i]);
            if (V_OK[i] == 1) chk("R3/R5 ok status", o, 1);
            else chk("R6 failed status", o, 0);
            chk("R4 pulse low width", bw, 0);
            chk("R2 reset held during run", bwin, 0);
            chk("R10 sda never driven", bs, 0);
        end

        // R9: extra start during a run changes nothing
        run(20, 1'b0, 1'b1, p, o, bw, bwin, bs);
        chk("R9 pulses unchanged by extra start", p, 20);
        chk("R9 ok after extra start", o, 1);

        // R10: outside a run SCL is never pulled
        repeat (10) @(negedge clk);
        chk("R10 scl released when idle", int'(scl_oe_o), 0);
        chk("R10 reset low when idle", int'(ctrl_rst_o), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule